// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a virtual address into a physical address through a small table of segment descriptors held on chip. The top bits of the virtual address pick one descriptor and the remaining bits are an offset inside that segment. Each descriptor holds a physical base, a size limit and a rights code. A lookup compares the offset with the limit and the requested access type with the rights. It then returns either base plus offset or a fault with a cause code. The result appears one clock after the request.

Software loads descriptors through a register-style write port. A separate combinational read port returns any descriptor, so the whole table can be saved and reloaded when the running process changes. The unit has one lookup path and one table, and it accepts one request per cycle.

Top module: `seg_xlate_unit`

## Requirements
- R1: The virtual address is 19 bits. Bits [18:16] select one of 8 table entries and bits [15:0] form the offset within that segment.
- R2: When a lookup does not fault, the response carries addr_ok=1, cause 0, and paddr = (base + offset) modulo 2^24. The offset is zero-extended to 24 bits before the add.
- R3: When the offset is strictly greater than the entry's 24-bit size, the response has cause 1 (bound), addr_ok=0 and paddr=0. An offset equal to the size is accepted.
- R4: Rights codes are 0 none, 1 read, 2 write and 3 execute. Access codes are 0 read, 1 write, 2 fetch and 3 reserved. A read is allowed by rights 1, 2 or 3. A write is allowed only by rights 2. A fetch is allowed only by rights 3. The reserved access code and rights 0 allow nothing.
- R5: A lookup that passes the bound check but is not allowed by the rights gives cause 2 (protection), addr_ok=0 and paddr=0. When both checks fail, cause 1 is reported. Cause 3 never appears.
- R6: rsp_valid is high in exactly the cycle after a cycle with req_valid high. While rsp_valid is low, addr_ok, cause and paddr are all zero.
- R7: A table write is applied at the clock edge on which tbl_wr_en is sampled high. A lookup presented in that same cycle uses the entry's previous contents, and the next lookup uses the new contents.
- R8: The read port returns the base, size and rights of the entry selected by tbl_rd_idx, combinationally, for every one of the 8 entries.
- R9: Reset clears every entry to base 0, size 0 and rights none, and clears rsp_valid. A lookup after reset therefore faults: offset 0 gives cause 2 and offset 1 gives cause 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 19 | Virtual address: segment number and offset |
| req_access | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | Registered result valid |
| rsp_addr_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | 24 | Physical address, zero on fault |
| rsp_cause | output | 2 | Fault cause: 0 none, 1 bound, 2 protection |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 3 | Entry to write |
| tbl_wr_base | input | 24 | Base to write |
| tbl_wr_size | input | 24 | Size limit to write |
| tbl_wr_rights | input | 2 | Rights code to write |
| tbl_rd_idx | input | 3 | Entry to read back |
| tbl_rd_base | output | 24 | Base of the selected entry |
| tbl_rd_size | output | 24 | Size limit of the selected entry |
| tbl_rd_rights | output | 2 | Rights code of the selected entry |

## Verification
The bench loads all eight entries with a different base, size and rights code in each, and one entry has a size beyond the 16-bit offset range. It then tries every access code at offsets 0, the size, the size plus one, a mid value and the maximum. The size and size-plus-one pair checks where the bound fires, and the four access codes against the four rights codes cover the whole permission matrix. Large bases show that the address wraps at 24 bits. Further cases cover the table right after reset, a write and a lookup to the same entry in the same cycle, and back-to-back idle cycles, which separate old contents from new and show that outputs are quiet between responses.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_READ  = 2'd1,
    RT_WRITE = 2'd2,
    RT_EXEC  = 2'd3
  } rights_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_BOUND = 2'd1,
    FLT_PROT  = 2'd2,
    FLT_RSVD  = 2'd3
  } cause_e;

  // Permission matrix: rows are rights codes, columns are access kinds.
  function automatic logic access_allowed(rights_e rt, acc_e acc);
    logic ok;
    ok = 1'b0;
    case (acc)
      ACC_READ:  ok = (rt != RT_NONE);
      ACC_WRITE: ok = (rt == RT_WRITE);
      ACC_FETCH: ok = (rt == RT_EXEC);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seg_entry_reg.sv
module seg_entry_reg #(
  parameter int PA_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PA_W-1:0] base_d,
  input  logic [PA_W-1:0] size_d,
  input  logic [1:0]      rights_d,
  output logic [PA_W-1:0] base_q,
  output logic [PA_W-1:0] size_q,
  output logic [1:0]      rights_q
);

  logic [PA_W-1:0] base_nx;
  logic [PA_W-1:0] size_nx;
  logic [1:0]      rights_nx;

  always_comb begin
    base_nx   = base_q;
    size_nx   = size_q;
    rights_nx = rights_q;
    if (load) begin
      base_nx   = base_d;
      size_nx   = size_d;
      rights_nx = rights_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      size_q   <= '0;
      rights_q <= 2'd0;
    end else begin
      base_q   <= base_nx;
      size_q   <= size_nx;
      rights_q <= rights_nx;
    end
  end

endmodule

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [PA_W-1:0]  wr_size,
  input  logic [1:0]       wr_rights,
  input  logic [SEG_W-1:0] lk_idx,
  output logic [PA_W-1:0]  lk_base,
  output logic [PA_W-1:0]  lk_size,
  output logic [1:0]       lk_rights,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [PA_W-1:0]  rd_size,
  output logic [1:0]       rd_rights
);

  localparam int NSEG = 1 << SEG_W;

  logic [NSEG-1:0]           load_vec;
  logic [NSEG-1:0][PA_W-1:0] ent_base;
  logic [NSEG-1:0][PA_W-1:0] ent_size;
  logic [NSEG-1:0][1:0]      ent_rights;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    assign load_vec[g] = wr_en && (wr_idx == SEG_W'(g));

    seg_entry_reg #(.PA_W(PA_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_vec[g]),
      .base_d   (wr_base),
      .size_d   (wr_size),
      .rights_d (wr_rights),
      .base_q   (ent_base[g]),
      .size_q   (ent_size[g]),
      .rights_q (ent_rights[g])
    );
  end

  // Lookup port: reads current contents, so a same-cycle write is not seen.
  always_comb begin
    lk_base   = ent_base[lk_idx];
    lk_size   = ent_size[lk_idx];
    lk_rights = ent_rights[lk_idx];
  end

  // Save/restore port.
  always_comb begin
    rd_base   = ent_base[rd_idx];
    rd_size   = ent_size[rd_idx];
    rd_rights = ent_rights[rd_idx];
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int PA_W  = 24
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [PA_W-1:0]  base,
  input  logic [PA_W-1:0]  size,
  input  logic [1:0]       rights,
  input  logic [1:0]       access,
  output logic [PA_W-1:0]  paddr,
  output logic             addr_ok,
  output logic [1:0]       cause
);

  localparam int PAD_W = PA_W - OFS_W;

  logic [PA_W-1:0] ofs_ext;
  logic            over_bound;
  logic            permitted;

  assign ofs_ext    = {{PAD_W{1'b0}}, offset};
  assign over_bound = (ofs_ext > size);
  assign permitted  = access_allowed(rights_e'(rights), acc_e'(access));

  always_comb begin
    cause   = FLT_NONE;
    addr_ok = 1'b0;
    paddr   = '0;
    if (over_bound) begin
      cause = FLT_BOUND;
    end else if (!permitted) begin
      cause = FLT_PROT;
    end else begin
      addr_ok = 1'b1;
      paddr   = base + ofs_ext;
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int SEG_W = 3,
  parameter int OFS_W = 16,
  parameter int PA_W  = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [SEG_W+OFS_W-1:0] req_vaddr,
  input  logic [1:0]             req_access,
  output logic                   rsp_valid,
  output logic                   rsp_addr_ok,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic [1:0]             rsp_cause,
  input  logic                   tbl_wr_en,
  input  logic [SEG_W-1:0]       tbl_wr_idx,
  input  logic [PA_W-1:0]        tbl_wr_base,
  input  logic [PA_W-1:0]        tbl_wr_size,
  input  logic [1:0]             tbl_wr_rights,
  input  logic [SEG_W-1:0]       tbl_rd_idx,
  output logic [PA_W-1:0]        tbl_rd_base,
  output logic [PA_W-1:0]        tbl_rd_size,
  output logic [1:0]             tbl_rd_rights
);

  localparam int VA_W = SEG_W + OFS_W;

  logic [SEG_W-1:0] seg_sel;
  logic [OFS_W-1:0] seg_ofs;
  logic [PA_W-1:0]  lk_base;
  logic [PA_W-1:0]  lk_size;
  logic [1:0]       lk_rights;
  logic [PA_W-1:0]  chk_paddr;
  logic             chk_ok;
  logic [1:0]       chk_cause;

  assign seg_sel = req_vaddr[VA_W-1:OFS_W];
  assign seg_ofs = req_vaddr[OFS_W-1:0];

  seg_table #(.SEG_W(SEG_W), .PA_W(PA_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_wr_en),
    .wr_idx    (tbl_wr_idx),
    .wr_base   (tbl_wr_base),
    .wr_size   (tbl_wr_size),
    .wr_rights (tbl_wr_rights),
    .lk_idx    (seg_sel),
    .lk_base   (lk_base),
    .lk_size   (lk_size),
    .lk_rights (lk_rights),
    .rd_idx    (tbl_rd_idx),
    .rd_base   (tbl_rd_base),
    .rd_size   (tbl_rd_size),
    .rd_rights (tbl_rd_rights)
  );

  seg_check #(.OFS_W(OFS_W), .PA_W(PA_W)) u_check (
    .offset  (seg_ofs),
    .base    (lk_base),
    .size    (lk_size),
    .rights  (lk_rights),
    .access  (req_access),
    .paddr   (chk_paddr),
    .addr_ok (chk_ok),
    .cause   (chk_cause)
  );

  // Response stage
  logic            rsp_en;
  logic            valid_nx;
  logic            ok_nx;
  logic [PA_W-1:0] paddr_nx;
  logic [1:0]      cause_nx;

  assign rsp_en = req_valid || rsp_valid;

  always_comb begin
    valid_nx = req_valid;
    ok_nx    = 1'b0;
    paddr_nx = '0;
    cause_nx = 2'd0;
    if (req_valid) begin
      ok_nx    = chk_ok;
      paddr_nx = chk_paddr;
      cause_nx = chk_cause;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_addr_ok <= 1'b0;
      rsp_paddr   <= '0;
      rsp_cause   <= 2'd0;
    end else if (rsp_en) begin
      rsp_valid   <= valid_nx;
      rsp_addr_ok <= ok_nx;
      rsp_paddr   <= paddr_nx;
      rsp_cause   <= cause_nx;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 3,
  parameter int OFS_W = 16,
  parameter int PA_W  = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [SEG_W+OFS_W-1:0] req_vaddr,
  input logic                   rsp_valid,
  input logic                   rsp_addr_ok,
  input logic [PA_W-1:0]        rsp_paddr,
  input logic [1:0]             rsp_cause,
  input logic                   tbl_wr_en,
  input logic [SEG_W-1:0]       tbl_wr_idx,
  input logic [PA_W-1:0]        tbl_wr_base,
  input logic [PA_W-1:0]        tbl_wr_size,
  input logic [1:0]             tbl_wr_rights,
  input logic [SEG_W-1:0]       tbl_rd_idx,
  input logic [PA_W-1:0]        tbl_rd_base,
  input logic [PA_W-1:0]        tbl_rd_size,
  input logic [1:0]             tbl_rd_rights
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R6
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (rsp_valid == $past(req_valid)));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_addr_ok && rsp_cause == 2'd0 && rsp_paddr == '0));

  // R3
  fault_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr_ok == (rsp_cause == 2'd0)));

  // R5
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cause != 2'd3);

  // R2
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_addr_ok |-> (rsp_paddr == '0));

  // R7
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(tbl_wr_en) && tbl_rd_idx == $past(tbl_wr_idx)) |->
      (tbl_rd_base == $past(tbl_wr_base) && tbl_rd_size == $past(tbl_wr_size)
       && tbl_rd_rights == $past(tbl_wr_rights)));

  // R1: address must be known whenever a request is strobed
  vaddr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$isunknown(req_vaddr));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;

  localparam int SEG_W = 3;
  localparam int OFS_W = 16;
  localparam int PA_W  = 24;
  localparam int NSEG  = 1 << SEG_W;

  logic                   clk;
  logic                   rst_n;
  logic                   req_valid;
  logic [SEG_W+OFS_W-1:0] req_vaddr;
  logic [1:0]             req_access;
  logic                   rsp_valid;
  logic                   rsp_addr_ok;
  logic [PA_W-1:0]        rsp_paddr;
  logic [1:0]             rsp_cause;
  logic                   tbl_wr_en;
  logic [SEG_W-1:0]       tbl_wr_idx;
  logic [PA_W-1:0]        tbl_wr_base;
  logic [PA_W-1:0]        tbl_wr_size;
  logic [1:0]             tbl_wr_rights;
  logic [SEG_W-1:0]       tbl_rd_idx;
  logic [PA_W-1:0]        tbl_rd_base;
  logic [PA_W-1:0]        tbl_rd_size;
  logic [1:0]             tbl_rd_rights;

  seg_xlate_unit #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [PA_W-1:0] m_base [NSEG];
  logic [PA_W-1:0] m_size [NSEG];
  logic [1:0]      m_rt   [NSEG];

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit allowed(input logic [1:0] rt, input logic [1:0] acc);
    case (acc)
      2'd0: return rt != 2'd0;
      2'd1: return rt == 2'd2;
      2'd2: return rt == 2'd3;
      default: return 1'b0;
    endcase
  endfunction

  task automatic write_entry(input int idx, input logic [PA_W-1:0] b,
                             input logic [PA_W-1:0] s, input logic [1:0] r);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = SEG_W'(idx);
    tbl_wr_base = b; tbl_wr_size = s; tbl_wr_rights = r;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    m_base[idx] = b; m_size[idx] = s; m_rt[idx] = r;
  endtask

  task automatic expect_rsp(input string tag, input int seg, input logic [OFS_W-1:0] ofs,
                            input logic [1:0] acc);
    logic [1:0]      ec;
    logic [PA_W-1:0] ep;
    if ({8'd0, ofs} > m_size[seg])   begin ec = 2'd1; ep = '0; end
    else if (!allowed(m_rt[seg], acc)) begin ec = 2'd2; ep = '0; end
    else begin ec = 2'd0; ep = m_base[seg] + {8'd0, ofs}; end
    check(tag, "valid", {31'd0, rsp_valid}, 32'd1);
    check(tag, "cause", {30'd0, rsp_cause}, {30'd0, ec});
    check(tag, "ok", {31'd0, rsp_addr_ok}, {31'd0, ec == 2'd0});
    check(tag, "paddr", {8'd0, rsp_paddr}, {8'd0, ep});
  endtask

  task automatic lookup(input string tag, input int seg, input logic [OFS_W-1:0] ofs,
                        input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {SEG_W'(seg), ofs}; req_access = acc;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(tag, seg, ofs, acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_access = 2'd0;
    tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_base = '0; tbl_wr_size = '0;
    tbl_wr_rights = 2'd0; tbl_rd_idx = '0;
    for (int i = 0; i < NSEG; i++) begin m_base[i] = '0; m_size[i] = '0; m_rt[i] = 2'd0; end
    repeat (3) @(negedge clk);
    check("R9", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R8: cleared table read back
    for (int i = 0; i < NSEG; i++) begin
      tbl_rd_idx = SEG_W'(i); #1;
      check("R9", "reset base", {8'd0, tbl_rd_base}, 32'd0);
      check("R9", "reset size", {8'd0, tbl_rd_size}, 32'd0);
      check("R9", "reset rights", {30'd0, tbl_rd_rights}, 32'd0);
    end
    lookup("R9", 0, 16'h0000, 2'd0);
    lookup("R9", 5, 16'h0001, 2'd0);

    // Load distinct entries
    for (int i = 0; i < NSEG; i++) begin
      logic [PA_W-1:0] b, s;
      b = 24'hF00000 + PA_W'(i) * 24'h01F3A1;
      s = (i < NSEG-1) ? 24'h000040 + PA_W'(i) * 24'h002001 : 24'h012345;
      write_entry(i, b, s, 2'(i % 4));
    end

    // R8: save path returns every entry
    @(negedge clk);
    for (int i = 0; i < NSEG; i++) begin
      tbl_rd_idx = SEG_W'(i); #1;
      check("R8", "rd base", {8'd0, tbl_rd_base}, {8'd0, m_base[i]});
      check("R8", "rd size", {8'd0, tbl_rd_size}, {8'd0, m_size[i]});
      check("R8", "rd rights", {30'd0, tbl_rd_rights}, {30'd0, m_rt[i]});
    end

    // R1 R2 R3 R4 R5: sweep segments, access codes and boundary offsets
    for (int s = 0; s < NSEG; s++) begin
      logic [OFS_W-1:0] sz16;
      sz16 = (m_size[s] > 24'h00FFFF) ? 16'hFFFF : m_size[s][15:0];
      for (int a = 0; a < 4; a++) begin
        lookup("R1", s, 16'h0000, 2'(a));
        lookup("R3", s, sz16, 2'(a));
        lookup("R3", s, sz16 + 16'd1, 2'(a));
        lookup("R4", s, 16'h7FFF, 2'(a));
        lookup("R5", s, 16'hFFFF, 2'(a));
      end
    end

    // R2: explicit wrap of base + offset at 24 bits
    write_entry(4, 24'hFFFF00, 24'h00FFFF, 2'd2);
    lookup("R2", 4, 16'h0200, 2'd1);
    check("R2", "wrapped paddr", {8'd0, rsp_paddr}, 32'h000100);

    // R6: outputs quiet in the idle cycle after a response
    @(negedge clk);
    check("R6", "idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R6", "idle ok", {31'd0, rsp_addr_ok}, 32'd0);
    check("R6", "idle paddr", {8'd0, rsp_paddr}, 32'd0);

    // R7: write and lookup to the same entry in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {3'd2, 16'h0010}; req_access = 2'd0;
    tbl_wr_en = 1'b1; tbl_wr_idx = 3'd2; tbl_wr_base = 24'h123400;
    tbl_wr_size = 24'h000020; tbl_wr_rights = 2'd1;
    @(negedge clk);
    req_valid = 1'b0; tbl_wr_en = 1'b0;
    expect_rsp("R7", 2, 16'h0010, 2'd0);
    m_base[2] = 24'h123400; m_size[2] = 24'h000020; m_rt[2] = 2'd1;
    lookup("R7", 2, 16'h0010, 2'd0);
    check("R7", "new paddr", {8'd0, rsp_paddr}, 32'h123410);

    // R6: back-to-back requests produce back-to-back responses
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {3'd2, 16'h0001}; req_access = 2'd0;
    @(negedge clk);
    expect_rsp("R6", 2, 16'h0001, 2'd0);
    req_vaddr = {3'd2, 16'h0021}; req_access = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R6", 2, 16'h0021, 2'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule